// File: doc/BRIEF.md
# Guarded Watchdog Timer

This block is a watchdog timer with a write-protected control register. Software enables the watchdog, picks one of eight timeout lengths and pulses a kick input often enough to stop the timeout counter from expiring. If the counter expires while the watchdog is enabled, the block emits a single-cycle reset request pulse and begins counting again from zero.

Turning the watchdog off, and in most modes changing its timeout, requires an unlock step. Software first writes the change-enable bit, which opens a short window. A later write inside that window may then clear the enable bit or load a new timeout select.

Two static strap inputs select one of three safety levels. The open level lets the timeout change at any time. The guarded level requires the unlock for both disabling and retiming. The locked level forces the watchdog on from reset and never lets it be switched off.

Top module: `wdt_guard`

## Requirements
- R1: The control register is 8 bits wide: bit 4 is change-enable, bit 3 is enable, bits 2:0 are the timeout select, and bits 7:5 always read zero. After reset every bit reads zero, except the enable bit in the locked level.
- R2: A write with bit 4 set makes change-enable read one for exactly 4 cycles, counted from the write's clock edge, after which it clears by itself. A further write with bit 4 set during the window restarts the 4-cycle count.
- R3: A write with bit 3 clear turns the watchdog off only if change-enable already read one before that write. A single write that sets bit 4 and clears bit 3 leaves an enabled watchdog on.
- R4: A write with bit 3 set enables the watchdog at once, with no unlock.
- R5: The straps select the safety level. Compatibility low and always-on low give the guarded level. Compatibility high and always-on low give the open level. Always-on high gives the locked level whatever the compatibility strap is. The open and guarded levels start disabled; the locked level starts enabled.
- R6: In the locked level the enable bit always reads one, and no write can clear it, unlocked or not.
- R7: In the open level every write loads bits 2:0 into the timeout select. In the guarded and locked levels a write loads them only while change-enable reads one; otherwise the select is unchanged.
- R8: With select N and the watchdog enabled, the reset output goes high for exactly one cycle 2^(N+4) cycles after the counter last restarted. The counter then restarts from zero.
- R9: A kick clears the counter without producing a pulse. While the watchdog is disabled, the counter stays at zero and no pulse is produced.
- R10: A write with bit 4 clear neither closes nor restarts an open change-enable window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_compat | input | 1 | Static compatibility strap |
| strap_always_on | input | 1 | Static always-on strap |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data |
| kick | input | 1 | Counter clear pulse |
| wdt_reset | output | 1 | One-cycle reset request |

## Verification
The bench builds the block with its defaults: a 3-bit select, a 4-cycle change-enable window and a tick shift of 4. Timeouts therefore run from 16 to 2048 cycles, so both a full timeout and the window expiry fit into short directed runs. Random writes are biased toward the lower half of the select range, so in the random phases the counter actually reaches expiry as well as being cut short by kicks. Every strap combination is applied under reset, which covers all three safety levels, including both strap encodings of the locked level.

// File: rtl/wdtg_pkg.sv
package wdtg_pkg;
   localparam int REG_W  = 8;
   localparam int CE_POS = 4;
   localparam int EN_POS = 3;

   typedef enum logic [1:0] {
      SAFE_OPEN    = 2'd0,
      SAFE_GUARDED = 2'd1,
      SAFE_LOCKED  = 2'd2
   } safety_e;
endpackage

// File: rtl/wdtg_level.sv
module wdtg_level
   import wdtg_pkg::*;
(
   input  logic    compat,
   input  logic    always_on,
   output safety_e level
);
   always_comb begin
      if (always_on)   level = SAFE_LOCKED;
      else if (compat) level = SAFE_OPEN;
      else             level = SAFE_GUARDED;
   end
endmodule

// File: rtl/wdtg_unlock.sv
module wdtg_unlock #(
   parameter int WINDOW = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   output logic open
);
   if (WINDOW < 1) begin : g_bad_window
      $error("wdtg_unlock: WINDOW must be at least 1");
   end

   if (WINDOW == 1) begin : g_flag
      logic flag_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) flag_q <= 1'b0;
         else        flag_q <= arm;
      end
      assign open = flag_q;
   end else begin : g_count
      localparam int CW = $clog2(WINDOW + 1);
      logic [CW-1:0] left_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)               left_q <= '0;
         else if (arm)             left_q <= CW'(WINDOW);
         else if (left_q != '0)    left_q <= left_q - CW'(1);
      end
      assign open = (left_q != '0);

      AST_WINDOW_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
         arm |=> (left_q == CW'(WINDOW)));                                   // R2
      AST_WINDOW_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
         (!arm && left_q != '0) |=> (left_q == $past(left_q) - CW'(1)));     // R10
   end
endmodule

// File: rtl/wdtg_ctrl.sv
module wdtg_ctrl
   import wdtg_pkg::*;
#(
   parameter int SEL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  safety_e          level,
   input  logic             wr,
   input  logic             wr_enable_bit,
   input  logic [SEL_W-1:0] wr_sel,
   input  logic             unlocked,
   output logic             en_eff,
   output logic [SEL_W-1:0] sel
);
   logic en_q;
   logic sel_allow;

   assign sel_allow = (level == SAFE_OPEN) || unlocked;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= 1'b0;
      end else if (wr) begin
         if (wr_enable_bit) en_q <= 1'b1;
         else if (unlocked) en_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                sel <= '0;
      else if (wr && sel_allow)  sel <= wr_sel;
   end

   assign en_eff = en_q || (level == SAFE_LOCKED);

   AST_EN_NEEDS_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (en_eff && wr && !wr_enable_bit && !unlocked) |=> en_eff);           // R3
   AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && wr_enable_bit) |=> en_eff);                                   // R4
   AST_SEL_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && level != SAFE_OPEN && !unlocked) |=> (sel == $past(sel)));   // R7
endmodule

// File: rtl/wdtg_timeout.sv
module wdtg_timeout #(
   parameter int SEL_W      = 3,
   parameter int TICK_SHIFT = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             kick,
   input  logic [SEL_W-1:0] sel,
   output logic             pulse
);
   localparam int NSEL  = 1 << SEL_W;
   localparam int CNT_W = TICK_SHIFT + NSEL;

   if (TICK_SHIFT < 1) begin : g_bad_shift
      $error("wdtg_timeout: TICK_SHIFT must be at least 1");
   end

   logic [CNT_W-1:0] last_tick [NSEL];
   logic [CNT_W-1:0] cnt_q;
   logic             expire;

   for (genvar g = 0; g < NSEL; g++) begin : g_limit
      assign last_tick[g] = (CNT_W'(1) << (g + TICK_SHIFT)) - CNT_W'(1);
   end

   assign expire = (cnt_q >= last_tick[sel]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         pulse <= 1'b0;
      end else if (!run || kick) begin
         cnt_q <= '0;
         pulse <= 1'b0;
      end else if (expire) begin
         cnt_q <= '0;
         pulse <= 1'b1;
      end else begin
         cnt_q <= cnt_q + CNT_W'(1);
         pulse <= 1'b0;
      end
   end

   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |=> !pulse);                                                   // R8
   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt_q == '0 && !pulse));                                   // R9
   AST_KICK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      kick |=> (cnt_q == '0 && !pulse));                                   // R9
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
   import wdtg_pkg::*;
#(
   parameter int SEL_W      = 3,
   parameter int CE_WINDOW  = 4,
   parameter int TICK_SHIFT = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             strap_compat,
   input  logic             strap_always_on,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] rd_data,
   input  logic             kick,
   output logic             wdt_reset
);
   if (SEL_W < 1 || SEL_W > EN_POS) begin : g_bad_sel
      $error("wdt_guard: SEL_W must fit below the enable bit");
   end

   safety_e          level;
   logic             ce_open;
   logic             en_eff;
   logic [SEL_W-1:0] sel;
   logic             rsvd_unused;

   assign rsvd_unused = ^wr_data[REG_W-1:CE_POS+1] ^ (^wr_data[EN_POS-1:SEL_W-1]);

   wdtg_level u_level (
      .compat    (strap_compat),
      .always_on (strap_always_on),
      .level     (level)
   );

   wdtg_unlock #(.WINDOW(CE_WINDOW)) u_unlock (
      .clk   (clk),
      .rst_n (rst_n),
      .arm   (wr_en && wr_data[CE_POS]),
      .open  (ce_open)
   );

   wdtg_ctrl #(.SEL_W(SEL_W)) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .level         (level),
      .wr            (wr_en),
      .wr_enable_bit (wr_data[EN_POS]),
      .wr_sel        (wr_data[SEL_W-1:0]),
      .unlocked      (ce_open),
      .en_eff        (en_eff),
      .sel           (sel)
   );

   wdtg_timeout #(.SEL_W(SEL_W), .TICK_SHIFT(TICK_SHIFT)) u_timeout (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (en_eff),
      .kick  (kick),
      .sel   (sel),
      .pulse (wdt_reset)
   );

   always_comb begin
      rd_data              = '0;
      rd_data[CE_POS]      = ce_open;
      rd_data[EN_POS]      = en_eff;
      rd_data[SEL_W-1:0]   = sel;
   end

   AST_LOCKED_READS_ON: assert property (@(posedge clk) disable iff (!rst_n)
      strap_always_on |-> rd_data[EN_POS]);                                // R6
   AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[REG_W-1:CE_POS+1] == '0);                                    // R1
endmodule

// File: tb/tb_wdt_guard.sv
module tb_wdt_guard;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       strap_compat = 1'b0;
   logic       strap_always_on = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic       kick = 1'b0;
   logic       wdt_reset;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   bit cmp_on = 1'b0;

   wdt_guard dut (
      .clk(clk), .rst_n(rst_n), .strap_compat(strap_compat),
      .strap_always_on(strap_always_on), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .kick(kick), .wdt_reset(wdt_reset)
   );

   always #10 clk = ~clk;

   // reference model, built from the requirements
   int unsigned m_ce, m_cnt;
   bit          m_en, m_pulse;
   bit [2:0]    m_sel;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ce = 0; m_cnt = 0; m_en = 0; m_pulse = 0; m_sel = 0;
      end else begin
         bit lv2, lv0, unl, run;
         int unsigned lim;
         lv2 = strap_always_on;
         lv0 = strap_compat && !strap_always_on;
         unl = (m_ce != 0);
         run = m_en || lv2;
         lim = 1 << (m_sel + 4);
         if (!run || kick) begin m_cnt = 0; m_pulse = 0; end
         else if (m_cnt >= lim - 1) begin m_cnt = 0; m_pulse = 1; end
         else begin m_cnt = m_cnt + 1; m_pulse = 0; end
         if (wr_en) begin
            if (wr_data[3]) m_en = 1;
            else if (unl)   m_en = 0;
            if (lv0 || unl) m_sel = wr_data[2:0];
         end
         if (wr_en && wr_data[4]) m_ce = 4;
         else if (m_ce != 0)      m_ce = m_ce - 1;
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h time=%0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (cmp_on && rst_n) begin
         bit exp_en;
         exp_en = m_en || strap_always_on;
         check(rd_data[7:5] == 3'b000, "R1 reserved bits", rd_data[7:5], 0);
         check(rd_data[4] == (m_ce != 0), "R2 change-enable", rd_data[4], int'(m_ce != 0));
         check(rd_data[3] == exp_en, strap_always_on ? "R6 enable" : "R3 enable",
               rd_data[3], exp_en);
         check(rd_data[2:0] == m_sel, "R7 select", rd_data[2:0], m_sel);
         check(wdt_reset == m_pulse, "R8 reset pulse", wdt_reset, m_pulse);
      end
   end

   task automatic report();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         failures++;
         $display("FAIL watchdog expired (all requirements) actual=%0d expected<=150000", cyc);
         report();
      end
   end

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic do_wr(input logic [7:0] d);
      wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = 8'h00;
   endtask

   task automatic do_reset(input bit cmp, input bit on);
      cmp_on = 1'b0;
      @(negedge clk);
      rst_n = 1'b0; wr_en = 1'b0; kick = 1'b0;
      strap_compat = cmp; strap_always_on = on;
      idle(2);
      rst_n = 1'b1;
      cmp_on = 1'b1;
      idle(1);
   endtask

   task automatic rand_phase(input int n);
      for (int i = 0; i < n; i++) begin
         logic [7:0] d;
         d = 8'($urandom);
         if ($urandom % 2 == 0) d[2] = 1'b0;
         wr_en   = ($urandom % 24 == 0);
         wr_data = d;
         kick    = ($urandom % 400 == 0);
         @(negedge clk);
      end
      wr_en = 1'b0; kick = 1'b0;
   endtask

   initial begin
      bit seen;
      void'($urandom(32'd20240611));

      // guarded level
      do_reset(1'b0, 1'b0);
      check(rd_data == 8'h00, "R1/R5 guarded reset value", rd_data, 8'h00);
      do_wr(8'h0B);
      check(rd_data == 8'h08, "R4 enable without unlock, R7 select held", rd_data, 8'h08);
      do_wr(8'h00);
      check(rd_data[3] == 1'b1, "R3 clear without unlock ignored", rd_data[3], 1);
      do_wr(8'h10);
      check(rd_data == 8'h18, "R3 same-write unlock does not disable", rd_data, 8'h18);
      do_wr(8'h06);
      check(rd_data == 8'h16, "R3/R7/R10 unlocked write, window stays open", rd_data, 8'h16);
      idle(2);
      check(rd_data[4] == 1'b1, "R2 window still open in 4th cycle", rd_data[4], 1);
      idle(1);
      check(rd_data == 8'h06, "R2 window closed after 4 cycles", rd_data, 8'h06);
      do_wr(8'h10);
      idle(2);
      do_wr(8'h10);
      idle(3);
      check(rd_data[4] == 1'b1, "R2 rewrite restarts window", rd_data[4], 1);
      idle(1);
      check(rd_data[4] == 1'b0, "R2 restarted window expires", rd_data[4], 0);

      // open level
      do_reset(1'b1, 1'b0);
      check(rd_data == 8'h00, "R5 open level starts disabled", rd_data, 8'h00);
      do_wr(8'h08);
      idle(15);
      check(wdt_reset == 1'b0, "R8 no pulse before 16 cycles", wdt_reset, 0);
      idle(1);
      check(wdt_reset == 1'b1, "R8 pulse after 16 cycles", wdt_reset, 1);
      idle(1);
      check(wdt_reset == 1'b0, "R8 pulse lasts one cycle", wdt_reset, 0);
      seen = 1'b0;
      for (int k = 0; k < 100; k++) begin
         kick = (k % 10 == 0);
         @(negedge clk);
         if (wdt_reset) seen = 1'b1;
      end
      kick = 1'b0;
      check(!seen, "R9 regular kicks prevent pulse", seen, 0);
      do_wr(8'h0D);
      check(rd_data[2:0] == 3'd5, "R7 open level free select change", rd_data[2:0], 5);
      do_wr(8'h10);
      do_wr(8'h00);
      check(rd_data[3] == 1'b0, "R3 unlocked disable", rd_data[3], 0);
      seen = 1'b0;
      for (int k = 0; k < 700; k++) begin
         @(negedge clk);
         if (wdt_reset) seen = 1'b1;
      end
      check(!seen, "R9 disabled watchdog never fires", seen, 0);

      // locked level
      do_reset(1'b0, 1'b1);
      check(rd_data == 8'h08, "R5/R6 locked level starts enabled", rd_data, 8'h08);
      do_wr(8'h10);
      do_wr(8'h00);
      check(rd_data[3] == 1'b1, "R6 unlocked disable ignored", rd_data[3], 1);
      idle(4);
      do_wr(8'h05);
      check(rd_data[2:0] == 3'd0, "R7 locked select needs unlock", rd_data[2:0], 0);
      do_wr(8'h10);
      do_wr(8'h05);
      check(rd_data[2:0] == 3'd5, "R7 locked select with unlock", rd_data[2:0], 5);

      // random phases over all strap combinations
      for (int s = 0; s < 4; s++) begin
         do_reset(s[0], s[1]);
         check(rd_data[3] == s[1], "R5 reset enable per straps", rd_data[3], s[1]);
         rand_phase(6000);
      end

      cmp_on = 1'b0;
      report();
   end
endmodule